// File: doc/BRIEF.md
# Receive Address-Match Filter Register

This block keeps one programmable address word for a receive channel and compares it with every address character that arrives on that channel. When a character is flagged valid, a single-cycle match pulse reports whether it hits the stored address. The stored word can behave as a unicast address, where every bit must agree, or as a multicast address, where agreement in any single bit position is enough. The choice is latched together with the value on each write.

Software and host logic reach the word through a side-band window on the receive data path. The window opens while the active-low receive-reset line and the active-low address-mode line are both low. An active-low enable strobe then starts a read or a write, and a direction line decides which. Because the window reuses the receive-reset line, the block also measures how long that line stays low. A short hold used for a register access never resets the receive FIFO. A long hold produces a one-cycle FIFO reset pulse.

The stored word and the comparison are 8 or 10 bits wide, chosen by a width-select input. Access works only in the cell-bus timing mode. When continuous selection is configured, writes are refused and the FIFO reset pulse is suppressed.

Top module: `rxaddr_filter`

## Requirements
- R1: When `cfg_wide` is 0, only bits 7:0 are stored and compared. Bits 9:8 of a written word are stored as 0 and are ignored in incoming addresses. When `cfg_wide` is 1, all ten bits take part.
- R2: When `cfg_cellbus` is 0, strobes have no effect. Writes leave the stored word unchanged and reads leave `bus_oe` low.
- R3: The access window is open only while `rst_req_n` and `amode_n` are both 0. A strobe with either one high does not write or read.
- R4: A write is a clock edge with the window open, `strobe_n` = 0 and `rd_wr` = 0. It stores `bus_in` and latches `mode_sel`, where 1 selects unicast and 0 selects multicast.
- R5: A read is a clock edge with the window open, `strobe_n` = 0 and `rd_wr` = 1. In the following cycle `bus_oe` is 1 and `bus_out` holds the stored word. Otherwise `bus_oe` is 0 and `bus_out` is 0.
- R6: In multicast mode, a valid address matches when at least one active bit position equals the stored bit.
- R7: In unicast mode, a valid address matches only when all active bits equal the stored word.
- R8: While `rst_req_n` is held at 0 for seven consecutive sampled clocks or fewer, `fifo_rst_pulse` stays 0. On the eighth consecutive low sample, `fifo_rst_pulse` is 1 for exactly one cycle. The count restarts whenever the line goes high.
- R9: While `cfg_contsel` is 1, writes are ignored and `fifo_rst_pulse` never rises.
- R10: `match_pulse` is registered. It is 1 in the cycle after an edge at which `addr_valid` is 1 and the address hits, and 0 in every other cycle.
- R11: After reset the stored word is 0, the mode is unicast, and `bus_oe`, `match_pulse` and `fifo_rst_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cfg_wide | input | 1 | 1 = 10-bit word, 0 = 8-bit word |
| cfg_cellbus | input | 1 | 1 = cell-bus timing mode, register window usable |
| cfg_contsel | input | 1 | 1 = continuous selection configured |
| rst_req_n | input | 1 | Active-low receive reset / window select |
| amode_n | input | 1 | Active-low address-mode select |
| strobe_n | input | 1 | Active-low access strobe |
| rd_wr | input | 1 | 1 = read, 0 = write, sampled at the strobe |
| mode_sel | input | 1 | Match mode latched on write: 1 unicast, 0 multicast |
| bus_in | input | 10 | Write data from the receive data bus |
| bus_out | output | 10 | Read data toward the receive data bus |
| bus_oe | output | 1 | Tri-state enable for `bus_out` |
| addr_valid | input | 1 | Incoming address character is valid |
| addr_char | input | 10 | Incoming address character |
| match_pulse | output | 1 | One-cycle match result |
| fifo_rst_pulse | output | 1 | One-cycle receive FIFO reset |

## Verification
The properties assume that every input is synchronous to `clk` and holds a known level at each rising edge. They also assume that configuration inputs change only while no access or hold measurement is in progress. The stimulus drives every input on the falling edge and changes `cfg_wide`, `cfg_cellbus` and `cfg_contsel` only between accesses. It keeps each register access to a single low cycle of `rst_req_n`, so that only the dedicated hold sequences reach the FIFO-reset threshold.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
   typedef enum logic {
      MATCH_ANY = 1'b0,
      MATCH_ALL = 1'b1
   } match_mode_e;

   typedef struct packed {
      logic open;
      logic wr;
      logic rd;
   } acc_cmd_t;
endpackage

// File: rtl/rxaf_decode.sv
module rxaf_decode
   import rxaf_pkg::*;
(
   input  logic     cfg_cellbus,
   input  logic     cfg_contsel,
   input  logic     rst_req_n,
   input  logic     amode_n,
   input  logic     strobe_n,
   input  logic     rd_wr,
   output acc_cmd_t cmd
);
   logic win_open;
   logic strobe;

   always_comb begin
      win_open = cfg_cellbus & ~rst_req_n & ~amode_n;
      strobe   = win_open & ~strobe_n;
      cmd.open = win_open;
      cmd.rd   = strobe & rd_wr;
      cmd.wr   = strobe & ~rd_wr & ~cfg_contsel;
   end
endmodule

// File: rtl/rxaf_store.sv
module rxaf_store
   import rxaf_pkg::*;
#(
   parameter int DW = 10
) (
   input  logic        clk,
   input  logic        rst_n,
   input  acc_cmd_t    cmd,
   input  logic [DW-1:0] mask,
   input  logic        mode_sel,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] addr_q,
   output match_mode_e mode_q,
   output logic [DW-1:0] rd_data,
   output logic        rd_oe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         mode_q <= MATCH_ALL;
      end else if (cmd.wr) begin
         addr_q <= wr_data & mask;
         mode_q <= mode_sel ? MATCH_ALL : MATCH_ANY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_oe   <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_oe   <= cmd.rd;
         rd_data <= cmd.rd ? addr_q : '0;
      end
   end
endmodule

// File: rtl/rxaf_compare.sv
module rxaf_compare
   import rxaf_pkg::*;
#(
   parameter int DW = 10
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [DW-1:0] mask,
   input  logic [DW-1:0] addr_q,
   input  match_mode_e mode_q,
   input  logic        addr_valid,
   input  logic [DW-1:0] addr_char,
   output logic        match_q
);
   logic [DW-1:0] same;
   logic [DW-1:0] agree_any;
   logic [DW-1:0] agree_all;
   logic          hit;

   for (genvar gi = 0; gi < DW; gi++) begin : g_bit
      assign same[gi]      = ~(addr_char[gi] ^ addr_q[gi]);
      assign agree_any[gi] = same[gi] & mask[gi];
      assign agree_all[gi] = same[gi] | ~mask[gi];
   end

   always_comb begin
      if (mode_q == MATCH_ALL) hit = &agree_all;
      else                     hit = |agree_any;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= addr_valid & hit;
   end
endmodule

// File: rtl/rxaf_hold.sv
module rxaf_hold #(
   parameter int HOLD_LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rst_req_n,
   input  logic cfg_contsel,
   output logic fifo_rst_q
);
   localparam int CW = $clog2(HOLD_LIMIT + 1);
   localparam logic [CW-1:0] LIM  = CW'(HOLD_LIMIT);
   localparam logic [CW-1:0] LAST = CW'(HOLD_LIMIT - 1);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt    <= '0;
         fifo_rst_q <= 1'b0;
      end else begin
         fifo_rst_q <= 1'b0;
         if (rst_req_n) begin
            run_cnt <= '0;
         end else begin
            if (run_cnt != LIM) run_cnt <= run_cnt + CW'(1);
            if (run_cnt == LAST && !cfg_contsel) fifo_rst_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rxaddr_filter.sv
module rxaddr_filter
   import rxaf_pkg::*;
#(
   parameter int DW         = 10,
   parameter int NW         = 8,
   parameter int HOLD_LIMIT = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wide,
   input  logic          cfg_cellbus,
   input  logic          cfg_contsel,
   input  logic          rst_req_n,
   input  logic          amode_n,
   input  logic          strobe_n,
   input  logic          rd_wr,
   input  logic          mode_sel,
   input  logic [DW-1:0] bus_in,
   output logic [DW-1:0] bus_out,
   output logic          bus_oe,
   input  logic          addr_valid,
   input  logic [DW-1:0] addr_char,
   output logic          match_pulse,
   output logic          fifo_rst_pulse
);
   if (NW < 1 || NW >= DW) begin : g_bad_width
      $error("rxaddr_filter: NW must lie in 1..DW-1");
   end
   if (HOLD_LIMIT < 2) begin : g_bad_hold
      $error("rxaddr_filter: HOLD_LIMIT must be at least 2");
   end

   acc_cmd_t      cmd;
   logic [DW-1:0] mask;
   logic [DW-1:0] addr_q;
   match_mode_e   mode_q;

   for (genvar gm = 0; gm < DW; gm++) begin : g_mask
      if (gm < NW) begin : g_low
         assign mask[gm] = 1'b1;
      end else begin : g_high
         assign mask[gm] = cfg_wide;
      end
   end

   rxaf_decode u_decode (
      .cfg_cellbus (cfg_cellbus),
      .cfg_contsel (cfg_contsel),
      .rst_req_n   (rst_req_n),
      .amode_n     (amode_n),
      .strobe_n    (strobe_n),
      .rd_wr       (rd_wr),
      .cmd         (cmd)
   );

   rxaf_store #(.DW(DW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .mask     (mask),
      .mode_sel (mode_sel),
      .wr_data  (bus_in),
      .addr_q   (addr_q),
      .mode_q   (mode_q),
      .rd_data  (bus_out),
      .rd_oe    (bus_oe)
   );

   rxaf_compare #(.DW(DW)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask       (mask),
      .addr_q     (addr_q),
      .mode_q     (mode_q),
      .addr_valid (addr_valid),
      .addr_char  (addr_char),
      .match_q    (match_pulse)
   );

   rxaf_hold #(.HOLD_LIMIT(HOLD_LIMIT)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .rst_req_n   (rst_req_n),
      .cfg_contsel (cfg_contsel),
      .fifo_rst_q  (fifo_rst_pulse)
   );
endmodule

// File: rtl/rxaf_chk.sv
module rxaf_chk #(
   parameter int DW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_cellbus,
   input logic          cfg_contsel,
   input logic          rst_req_n,
   input logic          amode_n,
   input logic          strobe_n,
   input logic          rd_wr,
   input logic [DW-1:0] bus_out,
   input logic          bus_oe,
   input logic          addr_valid,
   input logic          match_pulse,
   input logic          fifo_rst_pulse
);
   p_read_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> $past(cfg_cellbus && !rst_req_n && !amode_n && !strobe_n && rd_wr));

   p_quiet_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> (bus_out == '0));

   p_no_cellbus_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_cellbus |=> !bus_oe);

   p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req_n || amode_n) |=> !bus_oe);

   p_match_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> $past(addr_valid));

   p_fiforst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rst_pulse |=> !fifo_rst_pulse);

   p_fiforst_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rst_pulse |-> $past(!rst_req_n));

   p_fiforst_contsel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rst_pulse |-> $past(!cfg_contsel));
endmodule

bind rxaddr_filter rxaf_chk #(.DW(DW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_cellbus    (cfg_cellbus),
   .cfg_contsel    (cfg_contsel),
   .rst_req_n      (rst_req_n),
   .amode_n        (amode_n),
   .strobe_n       (strobe_n),
   .rd_wr          (rd_wr),
   .bus_out        (bus_out),
   .bus_oe         (bus_oe),
   .addr_valid     (addr_valid),
   .match_pulse    (match_pulse),
   .fifo_rst_pulse (fifo_rst_pulse)
);

// File: tb/sim_rxaddr_filter.sv
`timescale 1ns/1ps
module sim_rxaddr_filter;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_wide, cfg_cellbus, cfg_contsel;
   logic       rst_req_n, amode_n, strobe_n, rd_wr, mode_sel;
   logic [9:0] bus_in, bus_out, addr_char;
   logic       bus_oe, addr_valid, match_pulse, fifo_rst_pulse;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   rxaddr_filter u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_cellbus(cfg_cellbus),
      .cfg_contsel(cfg_contsel), .rst_req_n(rst_req_n), .amode_n(amode_n),
      .strobe_n(strobe_n), .rd_wr(rd_wr), .mode_sel(mode_sel), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .addr_valid(addr_valid),
      .addr_char(addr_char), .match_pulse(match_pulse), .fifo_rst_pulse(fifo_rst_pulse)
   );

   // {wide, unicast, write data, incoming address, expected match}
   localparam logic [22:0] VEC [10] = '{
      {1'b1, 1'b1, 10'h3A5, 10'h3A5, 1'b1},
      {1'b1, 1'b1, 10'h3A5, 10'h3A4, 1'b0},
      {1'b0, 1'b1, 10'h3A5, 10'h1A5, 1'b1},
      {1'b0, 1'b1, 10'h3A5, 10'h0A7, 1'b0},
      {1'b1, 1'b0, 10'h000, 10'h3FF, 1'b0},
      {1'b1, 1'b0, 10'h000, 10'h3FE, 1'b1},
      {1'b0, 1'b0, 10'h3FF, 10'h300, 1'b0},
      {1'b1, 1'b0, 10'h3FF, 10'h300, 1'b1},
      {1'b1, 1'b1, 10'h200, 10'h000, 1'b0},
      {1'b0, 1'b1, 10'h200, 10'h000, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic strobe_acc(input logic rd, input logic [9:0] d, input logic md,
                             input logic rr_n, input logic am_n);
      @(negedge clk);
      rst_req_n = rr_n; amode_n = am_n; strobe_n = 1'b0;
      rd_wr = rd; bus_in = d; mode_sel = md;
      @(negedge clk);
      rst_req_n = 1'b1; amode_n = 1'b1; strobe_n = 1'b1; rd_wr = 1'b1;
   endtask

   task automatic wr_reg(input logic [9:0] d, input logic md);
      strobe_acc(1'b0, d, md, 1'b0, 1'b0);
   endtask

   task automatic rd_reg(output logic [9:0] v, output logic oe);
      strobe_acc(1'b1, 10'h0, 1'b1, 1'b0, 1'b0);
      v = bus_out; oe = bus_oe;
   endtask

   task automatic try_match(input logic [9:0] a, output logic m);
      @(negedge clk);
      addr_valid = 1'b1; addr_char = a;
      @(negedge clk);
      addr_valid = 1'b0;
      m = match_pulse;
   endtask

   task automatic hold_low(input int cycles, output int pulses, output int at);
      pulses = 0; at = -1;
      @(negedge clk);
      rst_req_n = 1'b0;
      for (int i = 1; i <= cycles; i++) begin
         @(negedge clk);
         if (fifo_rst_pulse) begin pulses++; at = i; end
      end
      rst_req_n = 1'b1;
      @(negedge clk);
      if (fifo_rst_pulse) pulses++;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [9:0] v;
      logic       oe, m;
      int         np, at;
      rst_n = 1'b0; cfg_wide = 1'b1; cfg_cellbus = 1'b1; cfg_contsel = 1'b0;
      rst_req_n = 1'b1; amode_n = 1'b1; strobe_n = 1'b1; rd_wr = 1'b1;
      mode_sel = 1'b1; bus_in = '0; addr_valid = 1'b0; addr_char = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      chk("R11 bus_oe", bus_oe, 0);
      chk("R11 match_pulse", match_pulse, 0);
      chk("R11 fifo_rst_pulse", fifo_rst_pulse, 0);
      rd_reg(v, oe);
      chk("R11 stored word", v, 0);
      try_match(10'h000, m); chk("R11 unicast zero hit", m, 1);
      try_match(10'h001, m); chk("R11 unicast zero miss", m, 0);

      // R1 R4 R6 R7 vector walk
      for (int k = 0; k < 10; k++) begin
         cfg_wide = VEC[k][22];
         wr_reg(VEC[k][20:11], VEC[k][21]);
         try_match(VEC[k][10:1], m);
         chk($sformatf("R6/R7/R1 vector %0d", k), m, VEC[k][0]);
      end

      // R1 narrow readback clears bits 9:8
      cfg_wide = 1'b0;
      wr_reg(10'h3C3, 1'b1);
      rd_reg(v, oe);
      chk("R1 narrow readback", v, 10'h0C3);
      cfg_wide = 1'b1;

      // R4 R5 read timing
      wr_reg(10'h2B6, 1'b1);
      rd_reg(v, oe);
      chk("R5 oe after strobe", oe, 1);
      chk("R4 readback value", v, 10'h2B6);
      @(negedge clk);
      chk("R5 oe released", bus_oe, 0);
      chk("R5 bus idle zero", bus_out, 0);

      // R10 no pulse without valid
      @(negedge clk);
      addr_char = 10'h2B6; addr_valid = 1'b0;
      @(negedge clk);
      chk("R10 no valid no pulse", match_pulse, 0);
      try_match(10'h2B6, m);
      chk("R10 valid hit", m, 1);
      @(negedge clk);
      chk("R10 single cycle", match_pulse, 0);

      // R2 outside cell-bus mode
      cfg_cellbus = 1'b0;
      wr_reg(10'h155, 1'b1);
      rd_reg(v, oe);
      chk("R2 read ignored", oe, 0);
      cfg_cellbus = 1'b1;
      rd_reg(v, oe);
      chk("R2 write ignored", v, 10'h2B6);

      // R3 window needs both lines low
      strobe_acc(1'b0, 10'h0AA, 1'b1, 1'b0, 1'b1);
      strobe_acc(1'b0, 10'h0AA, 1'b1, 1'b1, 1'b0);
      strobe_acc(1'b1, 10'h000, 1'b1, 1'b1, 1'b0);
      chk("R3 read without reset line", bus_oe, 0);
      rd_reg(v, oe);
      chk("R3 writes ignored", v, 10'h2B6);

      // R8 hold length
      hold_low(7, np, at);
      chk("R8 seven cycles no reset", np, 0);
      hold_low(12, np, at);
      chk("R8 long hold one pulse", np, 1);
      chk("R8 pulse on eighth cycle", at, 8);
      hold_low(8, np, at);
      chk("R8 counter restarts", np, 1);

      // R9 continuous selection
      cfg_contsel = 1'b1;
      wr_reg(10'h011, 1'b0);
      hold_low(10, np, at);
      chk("R9 no fifo reset", np, 0);
      rd_reg(v, oe);
      chk("R9 write blocked", v, 10'h2B6);
      cfg_contsel = 1'b0;

      summary();
      $finish;
   end
endmodule